// File: doc/BRIEF.md
# Reference Frequency Lock Detector

This block decides whether a synthesized clock runs at the frequency it should, relative to an external reference. The synthesized serial clock has already been divided by four down to the parallel-rate clock before it arrives here. The reference may run at that parallel rate, or at one quarter, one eighth or one sixteenth of it. A two-bit selector tells the detector which of these holds, and it scales the count it expects from the synthesized clock to match.

Each measurement window lasts a fixed 2^WIN_LOG2 reference cycles. During the window the synthesized clock is counted in its own domain. At the end of the window the count crosses into the reference domain through a toggle request and acknowledge pair. It is then compared against the expected count, which is 2^WIN_LOG2 multiplied by the selected ratio.

The result drives an active-low lock output with hysteresis. An error of more than 500 ppm drops the output. Only an error below 250 ppm raises it again. An error between the two limits leaves the output as it was. The first window after reset starts from an arbitrary phase, so its count is discarded.

Top module: `refLockDetector`

## Requirements
- R1: `lockLostN` is 0 while reset is asserted and stays 0 after reset until at least the second completed window. The count from the first window is never used.
- R2: When the synthesized count differs from the expected count by more than 500 ppm in either direction (diff × LOSS_DIV > expected, LOSS_DIV = 2000), `lockLostN` goes to 0 after that window is evaluated.
- R3: When the difference is below 250 ppm (diff × LOCK_DIV < expected, LOCK_DIV = 4000), `lockLostN` goes to 1 after that window is evaluated.
- R4: When the difference lies between the two limits, `lockLostN` keeps its previous value, whether that value is 0 or 1.
- R5: `rateSel` sets the expected synthesized cycles per reference cycle: 0 gives 1, 1 gives 4, 2 gives 8 and 3 gives 16. With the synthesized clock at exactly that ratio, the detector locks.
- R6: When the synthesized clock runs at a ratio other than the one `rateSel` selects, `lockLostN` is 0.
- R7: `lockLostN` changes at most once per window. Two changes are always at least 2^WIN_LOG2 − 8 reference cycles apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| refClk | input | 1 | Reference clock; the measurement window is timed from it |
| synClk | input | 1 | Synthesized clock after the divide-by-four to parallel rate |
| rstN | input | 1 | Asynchronous active-low reset for both clock domains |
| rateSel | input | 2 | Ratio of synClk to refClk: 0→1, 1→4, 2→8, 3→16 |
| lockLostN | output | 1 | 1 when locked, 0 when lock is lost or not yet acquired |

## Verification
A fault in the window counter, the expected-count scaling or the crossing handshake shows up at the lock output one or two windows later. The output either fails to rise on a clean clock or stays high on an off-frequency one. A swapped threshold or a lost hold state shows up only when the error sits in the band between the two limits. For that reason the bench parks the clock inside that band, once from the locked state and once from the unlocked state. A decision made on the discarded first window would raise the output about one window too early after reset.

// File: rtl/lockDetPkg.sv
package lockDetPkg;

  // Strobes the control half hands to the datapath half.
  typedef struct packed {
    logic reqTgl;      // toggles at each window end (reference domain)
    logic captureStb;  // one-cycle pulse: sample the crossed count
  } ctrlStrobes_t;

  // log2 of the synthesized-to-reference ratio selected by rateSel.
  function automatic logic [2:0] rateShift(input logic [1:0] sel);
    case (sel)
      2'd0:    rateShift = 3'd0;
      2'd1:    rateShift = 3'd2;
      2'd2:    rateShift = 3'd3;
      default: rateShift = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/lockDatapath.sv
module lockDatapath
  import lockDetPkg::*;
#(
  parameter int WIN_LOG2 = 16,
  parameter int LOSS_DIV = 2000,
  parameter int LOCK_DIV = 4000
) (
  input  logic         refClk,
  input  logic         synClk,
  input  logic         rstN,
  input  logic [1:0]   rateSel,
  input  ctrlStrobes_t strb,
  output logic         ackTgl,
  output logic         tooFar,
  output logic         closeEnough
);

  localparam int CW = WIN_LOG2 + 7;
  localparam int PW = CW + 16;

  // Synthesized-clock domain: count cycles between window-end requests.
  logic [2:0]    reqSync;
  logic          reqEdge;
  logic [CW-1:0] synCnt;
  logic [CW-1:0] synHold;

  assign reqEdge = reqSync[2] ^ reqSync[1];

  always_ff @(posedge synClk or negedge rstN) begin
    if (!rstN) begin
      reqSync <= '0;
      synCnt  <= '0;
      synHold <= '0;
      ackTgl  <= 1'b0;
    end else begin
      reqSync <= {reqSync[1:0], strb.reqTgl};
      if (reqEdge) begin
        synHold <= synCnt;
        synCnt  <= CW'(1);
        ackTgl  <= ~ackTgl;
      end else if (synCnt != '1) begin
        synCnt <= synCnt + CW'(1);
      end
    end
  end

  // Reference domain: synHold is stable while captureStb samples it.
  logic [CW-1:0] refCount;
  logic [CW-1:0] expected;
  logic [CW-1:0] diff;

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) refCount <= '0;
    else if (strb.captureStb) refCount <= synHold;
  end

  assign expected = CW'(1) << (WIN_LOG2 + int'(rateShift(rateSel)));
  assign diff     = (refCount >= expected) ? refCount - expected
                                           : expected - refCount;

  assign tooFar      = (PW'(diff) * PW'(LOSS_DIV)) > PW'(expected);
  assign closeEnough = (PW'(diff) * PW'(LOCK_DIV)) < PW'(expected);

endmodule

// File: rtl/lockCtrl.sv
module lockCtrl
  import lockDetPkg::*;
#(
  parameter int WIN_LOG2 = 16
) (
  input  logic         refClk,
  input  logic         rstN,
  input  logic         ackTgl,
  input  logic         tooFar,
  input  logic         closeEnough,
  output ctrlStrobes_t strb,
  output logic         lockLostN
);

  logic [WIN_LOG2-1:0] winCnt;
  logic                reqTgl;
  logic [2:0]          ackSync;
  logic                captureStb;
  logic                decideStb;
  logic                primed;
  logic                lockState;

  assign captureStb = ackSync[2] ^ ackSync[1];

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      winCnt    <= '0;
      reqTgl    <= 1'b0;
      ackSync   <= '0;
      decideStb <= 1'b0;
      primed    <= 1'b0;
      lockState <= 1'b0;
    end else begin
      winCnt    <= winCnt + 1'b1;
      if (winCnt == '1) reqTgl <= ~reqTgl;
      ackSync   <= {ackSync[1:0], ackTgl};
      decideStb <= captureStb;
      if (decideStb) begin
        if (!primed)          primed    <= 1'b1;
        else if (tooFar)      lockState <= 1'b0;
        else if (closeEnough) lockState <= 1'b1;
      end
    end
  end

  assign strb.reqTgl     = reqTgl;
  assign strb.captureStb = captureStb;
  assign lockLostN       = lockState;

endmodule

// File: rtl/refLockDetector.sv
module refLockDetector
  import lockDetPkg::*;
#(
  parameter int WIN_LOG2 = 16,
  parameter int LOSS_DIV = 2000,
  parameter int LOCK_DIV = 4000
) (
  input  logic       refClk,
  input  logic       synClk,
  input  logic       rstN,
  input  logic [1:0] rateSel,
  output logic       lockLostN
);

  ctrlStrobes_t strb;
  logic         ackTgl;
  logic         tooFar;
  logic         closeEnough;

  lockCtrl #(.WIN_LOG2(WIN_LOG2)) ctrl (
    .refClk(refClk), .rstN(rstN), .ackTgl(ackTgl),
    .tooFar(tooFar), .closeEnough(closeEnough),
    .strb(strb), .lockLostN(lockLostN)
  );

  lockDatapath #(.WIN_LOG2(WIN_LOG2), .LOSS_DIV(LOSS_DIV), .LOCK_DIV(LOCK_DIV)) dp (
    .refClk(refClk), .synClk(synClk), .rstN(rstN), .rateSel(rateSel),
    .strb(strb), .ackTgl(ackTgl), .tooFar(tooFar), .closeEnough(closeEnough)
  );

endmodule

// File: rtl/refLockDetector_checker.sv
module refLockDetector_checker #(
  parameter int WIN_LOG2 = 16
) (
  input logic refClk,
  input logic rstN,
  input logic captureStb,
  input logic tooFar,
  input logic closeEnough,
  input logic lockLostN
);

  localparam int WIN = 1 << WIN_LOG2;

  int sinceRst;
  int sinceChange;
  int captures;
  logic prevLock;

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      sinceRst    <= 0;
      sinceChange <= 0;
      captures    <= 0;
      prevLock    <= 1'b0;
    end else begin
      prevLock <= lockLostN;
      if (sinceRst < (1 << 30)) sinceRst <= sinceRst + 1;
      if (prevLock != lockLostN) sinceChange <= 1;
      else if (sinceChange < (1 << 30)) sinceChange <= sinceChange + 1;
      if (captureStb && captures < 3) captures <= captures + 1;
    end
  end

  AST_RESET_LOW: assert property (@(posedge refClk) disable iff (!rstN)
    (lockLostN && !prevLock) |-> sinceRst >= 2 * WIN);  // R1

  AST_LOSS_DROPS: assert property (@(posedge refClk) disable iff (!rstN)
    ($past(captureStb) && tooFar && captures >= 2) |=> !lockLostN);  // R2

  AST_LOCK_RAISES: assert property (@(posedge refClk) disable iff (!rstN)
    ($past(captureStb) && closeEnough && captures >= 2) |=> lockLostN);  // R3

  AST_BAND_HOLDS: assert property (@(posedge refClk) disable iff (!rstN)
    ($past(captureStb) && !tooFar && !closeEnough && captures >= 2)
      |=> (lockLostN == prevLock));  // R4

  AST_LIMITS_DISJOINT: assert property (@(posedge refClk) disable iff (!rstN)
    !(tooFar && closeEnough));  // R2

  AST_ONE_PER_WINDOW: assert property (@(posedge refClk) disable iff (!rstN)
    (prevLock != lockLostN) |-> sinceChange >= WIN - 8);  // R7

endmodule

bind refLockDetector refLockDetector_checker #(.WIN_LOG2(WIN_LOG2)) chk (
  .refClk(refClk), .rstN(rstN), .captureStb(strb.captureStb),
  .tooFar(tooFar), .closeEnough(closeEnough), .lockLostN(lockLostN)
);

// File: tb/refLockDetector_test.sv
`timescale 1ns/1ps
module refLockDetector_test;

  localparam int WLOG = 12;
  localparam int WIN  = 1 << WLOG;

  logic refClk = 1'b0;
  logic synClk = 1'b0;
  logic rstN   = 1'b0;
  logic [1:0] rateSel = 2'd0;
  logic lockLostN;

  int  testsRun = 0;
  int  testsFailed = 0;
  real synRatio = 1.0;
  real synPpm   = 0.0;

  refLockDetector #(.WIN_LOG2(WLOG)) uut (
    .refClk(refClk), .synClk(synClk), .rstN(rstN),
    .rateSel(rateSel), .lockLostN(lockLostN)
  );

  always #4 refClk = ~refClk;  // 125 MHz

  // Synthesized clock with fine frequency offset kept in absolute real time.
  initial begin : synGen
    real nextT;
    nextT = 1.3;
    forever begin
      #(nextT - $realtime);
      synClk = ~synClk;
      nextT = nextT + 4.0 / (synRatio * (1.0 + synPpm * 1.0e-6));
    end
  end

  task automatic check(input string req, input logic got, input logic exp);
    testsRun++;
    if (got !== exp) begin
      testsFailed++;
      $display("FAIL %s: lockLostN=%0b expected %0b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(posedge refClk);
    @(negedge refClk);
  endtask

  task automatic setClock(input real ratio, input real ppm);
    synRatio = ratio;
    synPpm   = ppm;
  endtask

  // R1 and R5 (sel 0): low through reset and the discarded first window, then lock.
  task automatic testReset();
    setClock(1.0, 0.0);
    rateSel = 2'd0;
    rstN = 1'b0;
    waitCycles(10);
    check("R1 during reset", lockLostN, 1'b0);
    rstN = 1'b1;
    waitCycles(WIN + WIN / 2);
    check("R1 first window discarded", lockLostN, 1'b0);
    waitCycles(2 * WIN);
    check("R3/R5 sel0 lock", lockLostN, 1'b1);
  endtask

  // R5: each ratio locks when the clock matches it.
  task automatic testRatios();
    for (int s = 1; s < 4; s++) begin
      rateSel = 2'(s);
      setClock((s == 1) ? 4.0 : (s == 2) ? 8.0 : 16.0, 0.0);
      waitCycles(3 * WIN);
      check($sformatf("R5 sel%0d lock", s), lockLostN, 1'b1);
    end
  endtask

  // R2, R3, R4 at ratio 16: loss, band hold both ways, recovery.
  task automatic testThresholds();
    rateSel = 2'd3;
    setClock(16.0, 2000.0);
    waitCycles(3 * WIN);
    check("R2 +2000ppm loss", lockLostN, 1'b0);
    setClock(16.0, 370.0);
    waitCycles(3 * WIN);
    check("R4 band holds low", lockLostN, 1'b0);
    setClock(16.0, 0.0);
    waitCycles(3 * WIN);
    check("R3 relock", lockLostN, 1'b1);
    setClock(16.0, -370.0);
    waitCycles(3 * WIN);
    check("R4 band holds high", lockLostN, 1'b1);
    setClock(16.0, -2000.0);
    waitCycles(3 * WIN);
    check("R2 -2000ppm loss", lockLostN, 1'b0);
  endtask

  // R6: clock at a ratio the selector does not name.
  task automatic testWrongRatio();
    rateSel = 2'd0;
    setClock(1.0, 0.0);
    waitCycles(3 * WIN);
    check("R5 sel0 relock", lockLostN, 1'b1);
    setClock(4.0, 0.0);
    waitCycles(3 * WIN);
    check("R6 ratio mismatch", lockLostN, 1'b0);
  endtask

  initial begin : watchdog
    repeat (195000) @(posedge refClk);
    testsFailed++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", testsRun + 1, testsFailed);
    $finish;
  end

  initial begin
    testReset();
    testRatios();
    testThresholds();
    testWrongRatio();
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule